// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

A 32-bit processor core that finishes each instruction in one clock period. A program counter fetches a word from a private instruction memory. The register file supplies two operands, an ALU combines them, and the result, the loaded word or the next program counter value is committed on the following rising edge. Instruction words and data words are held in two separate word-addressed arrays inside the block.

A testbench fills both arrays through a load port, usually while reset is held. While the load port is active the core does not advance. The core supports nine operations: add, sub, and, or and signed set-less-than between registers, a word load, a word store, branch-if-equal and an absolute jump. Trace outputs show, for the instruction now being executed, its register write-back and its store.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, the program counter is 0. Out of reset, the program counter is always a multiple of 4, and the instruction at program counter P is taken from instruction word P/4.
- R2: Field positions are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], immediate [15:0] and jump field [25:0]. Opcode 0 is a register operation that writes rd. Function 0x01 writes rs+rt, 0x02 writes rs-rt, 0x03 writes rs AND rt, and 0x04 writes rs OR rt.
- R3: Function 0x05 (opcode 0) writes 1 to rd when rs < rt as signed two's-complement numbers, and writes 0 otherwise.
- R4: Opcode 0x08 (load) writes to rt the data word at byte address rs plus the sign-extended immediate. The data word index is that address divided by 4.
- R5: Opcode 0x09 (store) writes rt to the data word at byte address rs plus the sign-extended immediate. The trace outputs show this store, and no register write happens in the same cycle.
- R6: Opcode 0x04 (branch) sets the next program counter to PC+4+(sign-extended immediate × 4) when rs equals rt, and to PC+4 otherwise.
- R7: Opcode 0x02 (jump) sets the next program counter to bits [31:28] of PC+4 followed by the jump field and two zero bits.
- R8: Register 0 always reads as 0. A write to register 0 has no effect.
- R9: Any other opcode, and any opcode-0 word whose function value is not listed, writes nothing, stores nothing and advances the program counter by 4.
- R10: While load_en_i is high, the program counter holds, no register or data write from the core takes place, and load_data_i is written to word load_addr_i of the data memory (load_dmem_i=1) or of the instruction memory (load_dmem_i=0).
- R11: Every instruction completes in one cycle. An instruction that is not a branch or a jump advances the program counter by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Load port write strobe; stalls the core |
| load_dmem_i | input | 1 | Load target: 1 data memory, 0 instruction memory |
| load_addr_i | input | MEM_AW | Load word index |
| load_data_i | input | 32 | Load word |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Current instruction writes a register |
| wb_addr_o | output | 5 | Destination register number |
| wb_data_o | output | 32 | Value to be written |
| st_en_o | output | 1 | Current instruction stores to data memory |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store data |

## Verification
The assertions assume that the word fetched from instruction memory is already settled when an edge arrives. They also assume that the load port is used only while reset is held, or as a deliberate stall of a running program. The stimulus keeps to this. Each program is written with reset asserted and then released together with the load strobe, and the one stall taken in mid-run writes an instruction word that the program never reaches. Every load and store address in the programs is word aligned and falls inside the data array, so no check depends on how the index wraps.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_REG = 6'h00;
  localparam logic [5:0] OP_LD  = 6'h08;
  localparam logic [5:0] OP_ST  = 6'h09;
  localparam logic [5:0] OP_BEQ = 6'h04;
  localparam logic [5:0] OP_JMP = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h01;
  localparam logic [5:0] FN_SUB = 6'h02;
  localparam logic [5:0] FN_AND = 6'h03;
  localparam logic [5:0] FN_OR  = 6'h04;
  localparam logic [5:0] FN_SLT = 6'h05;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_wr;
    logic    dst_rd;
    logic    b_imm;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  logic    reg_class;
  alu_op_e fn_op;
  logic    fn_ok;

  // function decoder
  always_comb begin
    fn_ok = 1'b1;
    unique case (funct_i)
      FN_ADD:  fn_op = ALU_ADD;
      FN_SUB:  fn_op = ALU_SUB;
      FN_AND:  fn_op = ALU_AND;
      FN_OR:   fn_op = ALU_OR;
      FN_SLT:  fn_op = ALU_SLT;
      default: begin fn_op = ALU_ADD; fn_ok = 1'b0; end
    endcase
  end

  assign reg_class = (op_i == OP_REG);

  // main decoder
  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_ADD;
    if (reg_class) begin
      ctrl_o.reg_wr = fn_ok;
      ctrl_o.dst_rd = 1'b1;
      ctrl_o.alu_op = fn_op;
    end else begin
      unique case (op_i)
        OP_LD: begin
          ctrl_o.reg_wr = 1'b1;
          ctrl_o.b_imm  = 1'b1;
          ctrl_o.mem_rd = 1'b1;
        end
        OP_ST: begin
          ctrl_o.b_imm  = 1'b1;
          ctrl_o.mem_wr = 1'b1;
        end
        OP_BEQ: begin
          ctrl_o.branch = 1'b1;
          ctrl_o.alu_op = ALU_SUB;
        end
        OP_JMP:  ctrl_o.jump = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rd1_o = (ra1_i == '0) ? '0 : regs_q[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : regs_q[ra2_i];
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int W  = 32,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic              load_dmem_i,
  input  logic [MEM_AW-1:0] load_addr_i,
  input  logic [31:0]       load_data_i,
  output logic [31:0]       pc_o,
  output logic              wb_en_o,
  output logic [4:0]        wb_addr_o,
  output logic [31:0]       wb_data_o,
  output logic              st_en_o,
  output logic [31:0]       st_addr_o,
  output logic [31:0]       st_data_o
);
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  logic [XLEN-1:0] pc_q, pc4, pc_next, br_tgt, j_tgt;
  logic [XLEN-1:0] instr, simm, rs_val, rt_val, alu_b, alu_y, ld_data, wb_data;
  logic [RAW-1:0]  rs, rt, rd, wa;
  logic            alu_zero, run;
  ctrl_t           ctl;

  logic              dmem_we;
  logic [MEM_AW-1:0] dmem_waddr;
  logic [XLEN-1:0]   dmem_wdata;

  assign run = ~load_en_i;

  sc_mem #(.W(XLEN), .AW(MEM_AW)) u_imem (
    .clk_i   (clk_i),
    .we_i    (load_en_i & ~load_dmem_i),
    .waddr_i (load_addr_i),
    .wdata_i (load_data_i),
    .raddr_i (pc_q[MEM_AW+1:2]),
    .rdata_o (instr)
  );

  assign rs   = instr[25:21];
  assign rt   = instr[20:16];
  assign rd   = instr[15:11];
  assign simm = {{16{instr[15]}}, instr[15:0]};

  sc_ctrl u_ctrl (
    .op_i    (instr[31:26]),
    .funct_i (instr[5:0]),
    .ctrl_o  (ctl)
  );

  sc_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (rs),
    .ra2_i  (rt),
    .rd1_o  (rs_val),
    .rd2_o  (rt_val),
    .we_i   (run & ctl.reg_wr),
    .wa_i   (wa),
    .wd_i   (wb_data)
  );

  assign alu_b = ctl.b_imm ? simm : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .op_i   (ctl.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  // load port owns the data memory write path while active
  assign dmem_we    = load_en_i ? load_dmem_i : ctl.mem_wr;
  assign dmem_waddr = load_en_i ? load_addr_i : alu_y[MEM_AW+1:2];
  assign dmem_wdata = load_en_i ? load_data_i : rt_val;

  sc_mem #(.W(XLEN), .AW(MEM_AW)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dmem_we),
    .waddr_i (dmem_waddr),
    .wdata_i (dmem_wdata),
    .raddr_i (alu_y[MEM_AW+1:2]),
    .rdata_o (ld_data)
  );

  assign wb_data = ctl.mem_rd ? ld_data : alu_y;
  assign wa      = ctl.dst_rd ? rd : rt;

  assign pc4     = pc_q + 32'd4;
  assign br_tgt  = pc4 + (simm << 2);
  assign j_tgt   = {pc4[31:28], instr[25:0], 2'b00};
  assign pc_next = ctl.jump ? j_tgt :
                   (ctl.branch && alu_zero) ? br_tgt : pc4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  pc_q <= '0;
    else if (run) pc_q <= pc_next;
  end

  assign pc_o      = pc_q;
  assign wb_en_o   = run & ctl.reg_wr;
  assign wb_addr_o = wa;
  assign wb_data_o = wb_data;
  assign st_en_o   = run & ctl.mem_wr;
  assign st_addr_o = alu_y;
  assign st_data_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        load_en_i,
  input logic [31:0] pc_o,
  input logic        wb_en_o,
  input logic        st_en_o,
  input logic [31:0] instr
);
  logic [5:0]  op;
  logic        known_op, flow_op;
  logic [31:0] pc_plus4, jmp_dst;

  assign op       = instr[31:26];
  assign flow_op  = (op == OP_BEQ) || (op == OP_JMP);
  assign known_op = (op == OP_REG) || (op == OP_LD) || (op == OP_ST) || flow_op;
  assign pc_plus4 = pc_o + 32'd4;
  assign jmp_dst  = {pc_plus4[31:28], instr[25:0], 2'b00};

  p_pc_align_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);

  p_store_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_en_o |-> !wb_en_o);

  p_jump_dst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && op == OP_JMP) |=> pc_o == $past(jmp_dst));

  p_unknown_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && !known_op) |-> (!wb_en_o && !st_en_o));

  p_load_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> $stable(pc_o));

  p_load_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |-> (!wb_en_o && !st_en_o));

  p_seq_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && !flow_op) |=> pc_o == $past(pc_plus4));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_en_i (load_en_i),
  .pc_o      (pc_o),
  .wb_en_o   (wb_en_o),
  .st_en_o   (st_en_o),
  .instr     (instr)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW = 6;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_en = 1'b0;
  logic              load_dmem = 1'b0;
  logic [MEM_AW-1:0] load_addr = '0;
  logic [31:0]       load_data = '0;
  logic [31:0]       pc, wb_data, st_addr, st_data;
  logic [4:0]        wb_addr;
  logic              wb_en, st_en;

  int n_chk = 0;
  int n_bad = 0;

  sc_core #(.MEM_AW(MEM_AW)) u0 (
    .clk_i (clk), .rst_ni (rst_ni), .load_en_i (load_en),
    .load_dmem_i (load_dmem), .load_addr_i (load_addr), .load_data_i (load_data),
    .pc_o (pc), .wb_en_o (wb_en), .wb_addr_o (wb_addr), .wb_data_o (wb_data),
    .st_en_o (st_en), .st_addr_o (st_addr), .st_data_o (st_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'h02, 26'(tgt)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(logic dm, int a, logic [31:0] w);
    @(negedge clk);
    load_en = 1'b1; load_dmem = dm; load_addr = MEM_AW'(a); load_data = w;
    @(posedge clk);
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_ni = 1'b0;
  endtask

  task automatic go();
    @(negedge clk);
    load_en = 1'b0;
    rst_ni  = 1'b1;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic chk_wb(string tag, int a, logic [31:0] d);
    chk({tag, " wb_en"}, 32'(wb_en), 32'd1);
    chk({tag, " wb_addr"}, 32'(wb_addr), 32'(a));
    chk({tag, " wb_data"}, wb_data, d);
  endtask

  task automatic t_reset();
    hold_reset();
    #1;
    chk("R1 pc in reset", pc, 32'd0);
  endtask

  task automatic t_alu();
    hold_reset();
    put(1, 0, 32'd7);
    put(1, 1, 32'hFFFF_FFFD);
    put(0, 0, enc_i(6'h08, 0, 1, 0));
    put(0, 1, enc_i(6'h08, 0, 2, 4));
    put(0, 2, enc_r(1, 2, 3, 6'h01));
    put(0, 3, enc_r(1, 2, 4, 6'h02));
    put(0, 4, enc_r(1, 2, 5, 6'h03));
    put(0, 5, enc_r(1, 2, 6, 6'h04));
    put(0, 6, enc_r(2, 1, 7, 6'h05));
    put(0, 7, enc_r(1, 2, 8, 6'h05));
    go();
    chk("R1 pc after reset", pc, 32'd0);
    chk_wb("R4 load 7", 1, 32'd7);
    tick(); chk_wb("R4 load -3", 2, 32'hFFFF_FFFD);
    tick(); chk_wb("R2 add", 3, 32'd4);
    tick(); chk_wb("R2 sub", 4, 32'd10);
    tick(); chk_wb("R2 and", 5, 32'd5);
    tick(); chk_wb("R2 or", 6, 32'hFFFF_FFFF);
    tick(); chk_wb("R3 slt true", 7, 32'd1);
    tick(); chk_wb("R3 slt false", 8, 32'd0);
    chk("R11 pc step", pc, 32'd28);
  endtask

  task automatic t_mem();
    hold_reset();
    put(1, 3, 32'd12);
    put(0, 0, enc_i(6'h08, 0, 1, 12));
    put(0, 1, enc_i(6'h09, 1, 1, -4));
    put(0, 2, enc_i(6'h08, 1, 9, -4));
    go();
    chk_wb("R4 load base0", 1, 32'd12);
    tick();
    chk("R5 st_en", 32'(st_en), 32'd1);
    chk("R5 st_addr", st_addr, 32'd8);
    chk("R5 st_data", st_data, 32'd12);
    chk("R5 no wb", 32'(wb_en), 32'd0);
    tick(); chk_wb("R4 load neg offset", 9, 32'd12);
  endtask

  task automatic t_zero();
    hold_reset();
    put(1, 0, 32'd9);
    put(0, 0, enc_i(6'h08, 0, 1, 0));
    put(0, 1, enc_r(1, 1, 0, 6'h01));
    put(0, 2, enc_r(0, 1, 10, 6'h01));
    put(0, 3, enc_i(6'h08, 0, 0, 0));
    put(0, 4, enc_r(0, 0, 11, 6'h04));
    go();
    tick(); tick();
    chk_wb("R8 r0 after alu write", 10, 32'd9);
    tick(); tick();
    chk_wb("R8 r0 after load write", 11, 32'd0);
  endtask

  task automatic t_branch();
    hold_reset();
    put(1, 0, 32'd5);
    put(0, 0, enc_i(6'h08, 0, 1, 0));
    put(0, 1, enc_i(6'h04, 1, 0, 5));
    put(0, 2, enc_i(6'h04, 0, 0, 2));
    put(0, 5, enc_i(6'h04, 1, 1, -4));
    go();
    tick(); tick();
    chk("R6 not taken", pc, 32'd8);
    tick();
    chk("R6 taken forward", pc, 32'd20);
    tick();
    chk("R6 taken backward", pc, 32'd8);
  endtask

  task automatic t_jump_nop_stall();
    hold_reset();
    put(0, 0, enc_j(6));
    put(0, 6, enc_j(1));
    put(0, 1, {6'h3F, 26'h3FF_FFFF});
    put(0, 2, 32'd0);
    put(0, 3, enc_r(0, 0, 12, 6'h04));
    go();
    tick(); chk("R7 jump fwd", pc, 32'd24);
    tick(); chk("R7 jump back", pc, 32'd4);
    chk("R9 bad op no wb", 32'(wb_en), 32'd0);
    chk("R9 bad op no st", 32'(st_en), 32'd0);
    tick(); chk("R9 bad op pc+4", pc, 32'd8);
    chk("R9 bad funct no wb", 32'(wb_en), 32'd0);
    tick(); chk("R9 bad funct pc+4", pc, 32'd12);
    load_en = 1'b1; load_dmem = 1'b0; load_addr = MEM_AW'(40); load_data = 32'd0;
    #1;
    chk("R10 no wb while loading", 32'(wb_en), 32'd0);
    tick(); chk("R10 pc held", pc, 32'd12);
    tick(); chk("R10 pc still held", pc, 32'd12);
    load_en = 1'b0;
    #1;
    chk_wb("R10 resume", 12, 32'd0);
    tick(); chk("R11 resume step", pc, 32'd16);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_zero();
    t_branch();
    t_jump_nop_stall();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule